// File: doc/BRIEF.md
# Nonvolatile Memory Software Write Guard

This block sits between the host bus of a byte-wide parallel nonvolatile memory and the array's page-load interface. It samples the chip-enable, output-enable and write-enable strobes, the address and the data on every clock. From these it decides which host writes may reach the array. Writes from a WE low pulse that is too short are rejected. So are writes made while output-enable is low or chip-enable is high, and writes made while the power-good input is low.

Software protection starts disarmed, and in that state a bare write goes straight to the array as a single-byte load. A keyed three-write sequence arms protection and opens a page window. Up to a full page of bytes is then forwarded until the window closes by itself. It closes when the page fills, or when the gap between writes exceeds the byte-load interval. Once armed, protection stays armed, and bare writes are discarded. A six-write command disarms it again.

After each load the block holds a busy state for a fixed number of cycles. While busy, it ignores writes and inverts one status bit on every host read.

Top module: `nvm_write_guard`

## Requirements
- R1: With protection disarmed, a qualified write whose address and data do not start a keyed sequence is forwarded on `arr_we` with its address and data, and `busy` goes high.
- R2: The keyed writes data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555 arm protection and open a page window. The keyed writes themselves are not forwarded. Only the low 15 address bits are compared, so address bit 16 is ignored.
- R3: A window forwards at most PAGE_BYTES writes (default 256). The write that fills the page closes the window and starts `busy` without any further host action.
- R4: With protection armed, a write outside an open window is discarded and does not start `busy`.
- R5: A write whose address or data does not match the next keyed step returns the sequence to idle. With protection armed, that write is discarded.
- R6: An open window that receives no write for BLC_CYC cycles closes and starts `busy`, provided it holds at least one byte.
- R7: A partial keyed sequence that sees no write for BLC_CYC cycles returns to idle, so a later final step opens nothing.
- R8: A WE low pulse shorter than MIN_WE_CYC sampled cycles (default 3) starts no write. A pulse of exactly MIN_WE_CYC cycles is accepted.
- R9: A WE low pulse during which OE is low or CE is high at any sampled cycle starts no write.
- R10: While `pwr_good` is low, no write is started and `host_dout` reads 0x00.
- R11: While `busy`, each host read inverts bit 6 of `host_dout`, starting at 1 after a load. The other bits follow `arr_rdata`. When not busy, `host_dout` equals `arr_rdata`.
- R12: Writes made while `busy` is high are ignored.
- R13: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 disarm protection, so that a later bare write is forwarded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | High when the supply is above the sense threshold |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | ADDR_W | Host address |
| din | input | 8 | Host write data |
| arr_rdata | input | 8 | Read data from the array |
| host_dout | output | 8 | Read data returned to the host, with status while busy |
| arr_we | output | 1 | One-cycle strobe loading a byte into the array |
| arr_addr | output | ADDR_W | Address of the loaded byte |
| arr_data | output | 8 | Data of the loaded byte |
| arr_commit | output | 1 | One-cycle strobe that starts the internal write cycle |
| busy | output | 1 | High while the internal write cycle runs |

## Verification
The filter registers a write strobe on the clock edge that first samples WE high. The forwarded `arr_we` follows one edge later, and `busy` rises one edge after the commit. The bench therefore samples `busy` several cycles after a write ends. A scoreboard monitor compares every `arr_we` at the falling edge against the queue of writes the driver expects, which catches both missing writes and unexpected ones. Window timeouts fire BLC_CYC edges after the last accepted write, so the bench checks `busy` once well before that point and once well after it. Status-bit reads are sampled two falling edges after OE drops, which is after the single edge that flips the bit.

// File: rtl/nvm_guard_pkg.sv
// Package: shared constants, sequence state type and key matcher for the
// nonvolatile write guard. Assumes an 8-bit data bus and 15 compared address bits.
package nvm_guard_pkg;
    localparam int BYTE_W = 8;
    localparam int KEY_AW = 15;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_OPEN   = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_EXT    = 8'h80;
    localparam logic [BYTE_W-1:0] CMD_DISARM = 8'h20;
    localparam logic [KEY_AW-1:0] ADR_HI     = 15'h5555;
    localparam logic [KEY_AW-1:0] ADR_LO     = 15'h2AAA;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_E3, SQ_E4, SQ_E5, SQ_WIN
    } seq_e;

    function automatic logic key_hit(input logic [KEY_AW-1:0] a,
                                     input logic [BYTE_W-1:0] d,
                                     input logic [KEY_AW-1:0] ka,
                                     input logic [BYTE_W-1:0] kd);
        return (a == ka) && (d == kd);
    endfunction
endpackage

// File: rtl/nvm_we_filter.sv
// Module: qualifies host write pulses. A write strobe is issued on the cycle
// after WE is first sampled high, only if WE was low for at least MIN_WE_CYC
// sampled cycles with CE low, OE high and power good throughout.
// Assumes bus inputs are synchronous to clk and MIN_WE_CYC >= 2.
module nvm_we_filter
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int MIN_WE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(MIN_WE_CYC + 1);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_WE_CYC);

    logic [CNT_W-1:0] low_cnt;
    logic             spoil;

    // Measure the WE low width, flag inhibit conditions, strobe on WE rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            spoil   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!we_n) begin
                if (!ce_n && oe_n && pwr_good) begin
                    if (low_cnt != MIN_C) low_cnt <= low_cnt + 1'b1;
                    wr_addr <= addr;
                    wr_data <= din;
                end else begin
                    spoil <= 1'b1;
                end
            end else begin
                wr_stb  <= (low_cnt == MIN_C) && !spoil && pwr_good;
                low_cnt <= '0;
                spoil   <= 1'b0;
            end
        end
    end

    // R8
    stb_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(we_n) && !$past(we_n, 2)));

    // R10
    stb_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(pwr_good));
endmodule

// File: rtl/nvm_unlock_seq.sv
// Module: keyed sequence recogniser, protect flag, page window byte counter
// and byte-load timeout. Forwards permitted writes and issues the commit
// strobe that starts the internal write cycle. Expects wr_stb already gated
// by busy. A write that breaks a sequence while disarmed is passed as a bare write.
module nvm_unlock_seq
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_BYTES = 256,
    parameter int BLC_CYC    = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [BYTE_W-1:0] arr_data,
    output logic              arr_commit
);
    localparam int PCNT_W = $clog2(PAGE_BYTES + 1);
    localparam int TMR_W  = $clog2(BLC_CYC + 1);
    localparam logic [PCNT_W-1:0] LAST_BYTE = PCNT_W'(PAGE_BYTES - 1);
    localparam logic [TMR_W-1:0]  LAST_TICK = TMR_W'(BLC_CYC - 1);

    seq_e              state;
    logic              prot_en;
    logic [PCNT_W-1:0] bytes;
    logic [TMR_W-1:0]  tmr;
    logic [KEY_AW-1:0] ka;

    assign ka = wr_addr[KEY_AW-1:0];

    // Advance the key sequence, count window bytes and expire idle windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            prot_en    <= 1'b0;
            bytes      <= '0;
            tmr        <= '0;
            arr_we     <= 1'b0;
            arr_commit <= 1'b0;
            arr_addr   <= '0;
            arr_data   <= '0;
        end else begin
            arr_we     <= 1'b0;
            arr_commit <= 1'b0;
            if (wr_stb) begin
                tmr      <= '0;
                arr_addr <= wr_addr;
                arr_data <= wr_data;
                if (state == SQ_WIN) begin
                    arr_we <= 1'b1;
                    bytes  <= bytes + 1'b1;
                    if (bytes == LAST_BYTE) begin
                        arr_commit <= 1'b1;
                        state      <= SQ_IDLE;
                    end
                end else if (state == SQ_IDLE && key_hit(ka, wr_data, ADR_HI, KEY_FIRST)) begin
                    state <= SQ_K1;
                end else if (state == SQ_K1 && key_hit(ka, wr_data, ADR_LO, KEY_SECOND)) begin
                    state <= SQ_K2;
                end else if (state == SQ_K2 && key_hit(ka, wr_data, ADR_HI, CMD_OPEN)) begin
                    state   <= SQ_WIN;
                    prot_en <= 1'b1;
                    bytes   <= '0;
                end else if (state == SQ_K2 && key_hit(ka, wr_data, ADR_HI, CMD_EXT)) begin
                    state <= SQ_E3;
                end else if (state == SQ_E3 && key_hit(ka, wr_data, ADR_HI, KEY_FIRST)) begin
                    state <= SQ_E4;
                end else if (state == SQ_E4 && key_hit(ka, wr_data, ADR_LO, KEY_SECOND)) begin
                    state <= SQ_E5;
                end else if (state == SQ_E5 && key_hit(ka, wr_data, ADR_HI, CMD_DISARM)) begin
                    state   <= SQ_IDLE;
                    prot_en <= 1'b0;
                end else begin
                    state <= SQ_IDLE;
                    if (!prot_en) begin
                        arr_we     <= 1'b1;
                        arr_commit <= 1'b1;
                    end
                end
            end else if (state != SQ_IDLE) begin
                if (tmr == LAST_TICK) begin
                    tmr   <= '0;
                    state <= SQ_IDLE;
                    if (state == SQ_WIN && bytes != '0) arr_commit <= 1'b1;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    // R4
    drop_when_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (!$past(prot_en) || $past(state) == SQ_WIN));

    // R3
    page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bytes <= PCNT_W'(PAGE_BYTES));

    // R2
    arm_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> state == SQ_WIN);

    // R13
    disarm_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_en) |-> $past(state) == SQ_E5);
endmodule

// File: rtl/nvm_busy_status.sv
// Module: internal write-cycle timer and host read-back path. Busy lasts
// WC_CYC cycles after each commit; each host read (OE falling with CE low,
// WE high, power good) while busy inverts the status bit returned on bit 6.
module nvm_busy_status
    import nvm_guard_pkg::*;
#(
    parameter int WC_CYC = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              commit,
    input  logic [BYTE_W-1:0] arr_rdata,
    output logic              busy,
    output logic [BYTE_W-1:0] host_dout
);
    localparam int WC_W = $clog2(WC_CYC + 1);

    logic [WC_W-1:0] wc_cnt;
    logic            oe_q;
    logic            tog;
    logic            rd_stb;

    assign busy   = (wc_cnt != '0);
    assign rd_stb = oe_q && !oe_n && !ce_n && we_n && pwr_good;

    // Run the write-cycle timer and flip the status bit on reads while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc_cnt <= '0;
            oe_q   <= 1'b1;
            tog    <= 1'b0;
        end else begin
            oe_q <= oe_n;
            if (commit) begin
                wc_cnt <= WC_W'(WC_CYC);
                tog    <= 1'b0;
            end else begin
                if (busy) wc_cnt <= wc_cnt - 1'b1;
                if (rd_stb && busy) tog <= ~tog;
            end
        end
    end

    // Select status or array data for the host.
    always_comb begin
        if (!pwr_good)  host_dout = '0;
        else if (busy)  host_dout = {arr_rdata[7], tog, arr_rdata[5:0]};
        else            host_dout = arr_rdata;
    end

    // R1
    busy_from_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    // R11
    tog_moves_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog) |-> ($past(commit) || ($past(rd_stb) && $past(busy))));
endmodule

// File: rtl/nvm_write_guard.sv
// Module: top of the software write guard. Filters host write pulses, blocks
// them while the internal write cycle runs, applies the keyed protection
// sequence and returns read data with busy status. Bus inputs are assumed
// synchronous to clk.
module nvm_write_guard
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int MIN_WE_CYC = 3,
    parameter int PAGE_BYTES = 256,
    parameter int BLC_CYC    = 200,
    parameter int WC_CYC     = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        host_dout,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data,
    output logic              arr_commit,
    output logic              busy
);
    logic              raw_stb;
    logic              stb_ok;
    logic [ADDR_W-1:0] f_addr;
    logic [BYTE_W-1:0] f_data;

    assign stb_ok = raw_stb && !busy;

    nvm_we_filter #(.ADDR_W(ADDR_W), .MIN_WE_CYC(MIN_WE_CYC)) u_filter (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .wr_stb(raw_stb), .wr_addr(f_addr), .wr_data(f_data)
    );

    nvm_unlock_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BLC_CYC(BLC_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(stb_ok), .wr_addr(f_addr),
        .wr_data(f_data), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .arr_commit(arr_commit)
    );

    nvm_busy_status #(.WC_CYC(WC_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .commit(arr_commit), .arr_rdata(arr_rdata),
        .busy(busy), .host_dout(host_dout)
    );

    // R12
    busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stb && busy) |=> !arr_we);
endmodule

// File: tb/nvm_write_guard_tb.sv
// Scoreboard bench: bus tasks push expected array writes into a queue and a
// monitor compares every arr_we against it at the falling edge.
module nvm_write_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 17;
    localparam int BLC   = 200;
    localparam int PAGE  = 256;
    localparam logic [7:0] RD_VAL = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    arr_rdata = RD_VAL;
    logic [7:0]    host_dout;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_data;
    logic          arr_commit;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R1";
    logic [AW+7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_write_guard u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .arr_rdata(arr_rdata), .host_dout(host_dout), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data), .arr_commit(arr_commit),
        .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: every array write must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected array write actual %0h expected none",
                         cur_tag, {arr_addr, arr_data});
            end else begin
                logic [AW+7:0] e;
                e = exp_q.pop_front();
                if (e != {arr_addr, arr_data}) begin
                    errors++;
                    $display("FAIL %s array write actual %0h expected %0h",
                             cur_tag, {arr_addr, arr_data}, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d,
                             input int low = 4, input int inh = 0);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        if (inh == 1) oe_n = 1'b0;
        if (inh == 2) ce_n = 1'b1;
        repeat (low) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_write(input logic [AW-1:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
        bus_write(a, d);
    endtask

    task automatic host_read(output logic [7:0] v);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        v = host_dout;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock(input logic [AW-1:0] first_adr);
        bus_write(first_adr, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'hA0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(busy == 1'b0, "R11 reset busy", busy, 0);
        check(host_dout == RD_VAL, "R11 reset readback", host_dout, RD_VAL);

        // R1 direct write while disarmed, R12 write during busy ignored
        cur_tag = "R1";
        expect_write(17'h00123, 8'h5A);
        check(busy == 1'b1, "R1 busy after direct write", busy, 1);
        cur_tag = "R12";
        bus_write(17'h00200, 8'h11);
        // R11 status toggling while busy
        host_read(rv);
        check(rv == (RD_VAL | 8'h40), "R11 first busy read", rv, RD_VAL | 8'h40);
        host_read(rv);
        check(rv == RD_VAL, "R11 second busy read", rv, RD_VAL);
        host_read(rv);
        check(rv == (RD_VAL | 8'h40), "R11 third busy read", rv, RD_VAL | 8'h40);
        wait_idle();
        host_read(rv);
        check(rv == RD_VAL, "R11 read after cycle", rv, RD_VAL);
        check(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);

        // R8 glitch rejected, minimum width accepted
        cur_tag = "R8";
        bus_write(17'h00300, 8'h22, 2);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 short pulse no cycle", busy, 0);
        exp_q.push_back({17'h00301, 8'h23});
        bus_write(17'h00301, 8'h23, 3);
        check(busy == 1'b1, "R8 minimum pulse accepted", busy, 1);
        wait_idle();

        // R9 write inhibit by OE low or CE high
        cur_tag = "R9";
        bus_write(17'h00400, 8'h33, 4, 1);
        bus_write(17'h00401, 8'h34, 4, 2);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 inhibited writes", busy, 0);

        // R10 power-good low
        cur_tag = "R10";
        pwr_good = 1'b0;
        bus_write(17'h00500, 8'h44);
        @(negedge clk);
        check(host_dout == 8'h00, "R10 readback while unpowered", host_dout, 0);
        check(busy == 1'b0, "R10 no cycle while unpowered", busy, 0);
        pwr_good = 1'b1;
        repeat (2) @(negedge clk);

        // R2 unlock with address bit 16 set, R6 timeout closes window
        cur_tag = "R2";
        unlock(17'h15555);
        check(busy == 1'b0, "R2 keyed writes not forwarded", busy, 0);
        expect_write(17'h00600, 8'h61);
        expect_write(17'h00601, 8'h62);
        expect_write(17'h00602, 8'h63);
        cur_tag = "R6";
        repeat (BLC / 2) @(negedge clk);
        check(busy == 1'b0, "R6 window still open", busy, 0);
        repeat (BLC) @(negedge clk);
        check(busy == 1'b1, "R6 timeout commits page", busy, 1);
        check(exp_q.size() == 0, "R2 page bytes forwarded", exp_q.size(), 0);
        wait_idle();

        // R4 bare write dropped while armed
        cur_tag = "R4";
        bus_write(17'h00700, 8'h71);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R4 bare write dropped", busy, 0);

        // R5 broken sequence aborts
        cur_tag = "R5";
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h01234, 8'h55);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00777, 8'h77);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R5 aborted sequence opens nothing", busy, 0);

        // R7 sequence timeout
        cur_tag = "R7";
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        repeat (BLC + 20) @(negedge clk);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00888, 8'h88);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R7 expired sequence opens nothing", busy, 0);

        // R3 full page closes the window by itself
        cur_tag = "R3";
        unlock(17'h05555);
        for (int i = 0; i < PAGE; i++) begin
            logic [7:0] b;
            b = 8'(i) ^ 8'hA5;
            expect_write(AW'(i) | 17'h01000, b);
        end
        check(busy == 1'b1, "R3 full page commits", busy, 1);
        check(exp_q.size() == 0, "R3 all page bytes forwarded", exp_q.size(), 0);
        wait_idle();
        bus_write(17'h01100, 8'h99);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R3 window closed after page", busy, 0);

        // R13 disarm command
        cur_tag = "R13";
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h80);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h20);
        check(busy == 1'b0, "R13 command not forwarded", busy, 0);
        expect_write(17'h00900, 8'h90);
        check(busy == 1'b1, "R13 bare write passes after disarm", busy, 1);
        wait_idle();
        check(exp_q.size() == 0, "R13 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule